// File: doc/BRIEF.md
# Coprocessor Store Bus Sequencer

This block runs the memory bus on the core side while a coprocessor-to-memory store instruction executes. A start pulse captures the current program counter and the computed base address. The block then drives the bus one cycle at a time. It starts with a decode cycle that also announces the instruction to the coprocessor. Next come as many internal wait cycles as the coprocessor asks for. Last comes a run of word writes to incrementing addresses, with the coprocessor supplying the data on each one.

The coprocessor decides both lengths through two handshake inputs, `cp_absent_i` and `cp_busy_i`. During the decode and wait cycles, absent low with busy high means wait, and absent low with busy low means ready. During the transfer cycles, both low means more words follow, and both high marks the final word. If absent is high during the decode or a wait cycle, the block stops, pulses `absent_o`, and writes nothing.

After the final word, the block spends one cycle handing the bus back, with the next fetch address on the bus and `done_o` high. It then returns to idle. The bus controls follow the handshake inputs within the same cycle, so the memory request for the first transfer is already set up on the last wait cycle.

Top module: `csq_store_seq`

## Requirements
- R1: In idle, and during reset, the block drives address 0, size code 0, write 0, request_n 1, sequential 0, opcode_n 1, coprocessor-strobe_n 1, done 0 and absent 0.
- R2: The cycle after an accepted start is the decode cycle. It drives address pc+8, size code 2, write 0, sequential 0, opcode_n 0 and strobe_n 0. Its request_n equals absent OR busy as sampled in that cycle.
- R3: In each wait cycle, the block drives address pc+8, size code 2, write 0, sequential 0, opcode_n 1 and strobe_n 0. Request_n follows busy: it is 1 while busy is high and 0 on the wait cycle where busy drops.
- R4: In every transfer cycle, the block drives write 1, size code 2, request_n 0, opcode_n 1 and strobe_n 1, and puts `cp_wdata_i` on `mem_wdata_o`. The first transfer goes to the captured base address, and each later transfer goes to the previous address plus 4.
- R5: Sequential is 1 in every transfer cycle where absent and busy are not both high. It is 0 in the final transfer, which is the one where absent and busy are both high.
- R6: The cycle after the final transfer drives address pc+12, size code 2, write 0, request_n 1, sequential 0, opcode_n 0, strobe_n 1 and done 1. The next cycle is idle, so done lasts exactly one cycle.
- R7: Absent high during the decode cycle or a wait cycle causes the following things. The next cycle is idle with `absent_o` high for that one cycle. No transfer occurs, and done is not raised.
- R8: A start pulse that arrives while the block is not idle has no effect. The running sequence keeps its captured pc and base, and the block returns to idle after its done cycle.
- R9: Address arithmetic wraps modulo 2^32. For example, a base of 0xFFFFFFF8 gives transfers at 0xFFFFFFF8, 0xFFFFFFFC, 0x00000000 and 0x00000004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a store sequence when the block is idle |
| pc_i | input | 32 | Program counter of the store instruction, captured on start |
| base_i | input | 32 | Address of the first word written, captured on start |
| cp_absent_i | input | 1 | Coprocessor handshake: absent / final-word marker |
| cp_busy_i | input | 1 | Coprocessor handshake: busy / final-word marker |
| cp_wdata_i | input | 32 | Store data supplied by the coprocessor |
| mem_addr_o | output | 32 | Memory address |
| mem_size_o | output | 2 | Access size code (2 = word) |
| mem_write_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 32 | Write data, zero outside transfers |
| mem_req_n_o | output | 1 | Active-low memory request for the following cycle |
| mem_seq_o | output | 1 | The following access is sequential |
| opc_n_o | output | 1 | Active-low opcode-fetch flag |
| cpi_n_o | output | 1 | Active-low coprocessor-instruction strobe |
| done_o | output | 1 | One-cycle pulse on the hand-back cycle |
| absent_o | output | 1 | One-cycle pulse when the coprocessor reported absent |

## Verification
Each phase has its own combination of write, opcode_n and strobe_n. A wrong phase state therefore shows on the ports in the same cycle it is entered. Examples are a wait cycle that drops the strobe or a transfer that never writes. A fault in the transfer address pointer only appears on the second and later words of a burst, so multi-word bursts are needed, including one that crosses the top of the address space. A lost or stuck capture of the pc shows up only in the decode, wait and hand-back addresses. It is exposed by sending a second start in the middle of a burst.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_XFER   = 3'd3,
    ST_HAND   = 3'd4
  } csq_state_e;

  typedef struct packed {
    logic [1:0] size;
    logic       write;
    logic       req_n;
    logic       seq;
    logic       opc_n;
    logic       cpi_n;
  } csq_ctl_t;

  localparam csq_ctl_t CTL_IDLE = '{size: 2'd0, write: 1'b0, req_n: 1'b1,
                                   seq: 1'b0, opc_n: 1'b1, cpi_n: 1'b1};

endpackage

// File: rtl/csq_rst_sync.sv
module csq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/csq_ctrl.sv
module csq_ctrl
  import csq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cpa_i,
  input  logic       cpb_i,
  output csq_state_e state_o,
  output logic       load_o,
  output logic       step_o,
  output logic       absent_o
);
  csq_state_e st_q, st_d;
  logic       absent_q, absent_d;

  always_comb begin
    st_d     = st_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    absent_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_DECODE;
          load_o = 1'b1;
        end
      end
      ST_DECODE, ST_WAIT: begin
        if (cpa_i) begin
          st_d     = ST_IDLE;
          absent_d = 1'b1;
        end else if (cpb_i) begin
          st_d = ST_WAIT;
        end else begin
          st_d = ST_XFER;
        end
      end
      ST_XFER: begin
        step_o = 1'b1;
        if (cpa_i && cpb_i) st_d = ST_HAND;
      end
      ST_HAND: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      absent_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      absent_q <= absent_d;
    end
  end

  assign state_o  = st_q;
  assign absent_o = absent_q;
endmodule

// File: rtl/csq_addr.sv
module csq_addr #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic [AW-1:0] resume_addr_o,
  output logic [AW-1:0] xfer_addr_o
);
  localparam logic [AW-1:0] STEP_OFF   = AW'(WORD_BYTES);
  localparam logic [AW-1:0] FETCH_OFF  = AW'(2 * WORD_BYTES);
  localparam logic [AW-1:0] RESUME_OFF = AW'(3 * WORD_BYTES);

  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    pc_d  = pc_q;
    ptr_d = ptr_q;
    if (load_i) begin
      pc_d  = pc_i;
      ptr_d = base_i;
    end else if (step_i) begin
      ptr_d = ptr_q + STEP_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ptr_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ptr_q <= ptr_d;
    end
  end

  assign fetch_addr_o  = pc_q + FETCH_OFF;
  assign resume_addr_o = pc_q + RESUME_OFF;
  assign xfer_addr_o   = ptr_q;
endmodule

// File: rtl/csq_drive.sv
module csq_drive
  import csq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WORD_BYTES = DW / 8
) (
  input  csq_state_e    state_i,
  input  logic          cpa_i,
  input  logic          cpb_i,
  input  logic [DW-1:0] cp_wdata_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [AW-1:0] resume_addr_i,
  input  logic [AW-1:0] xfer_addr_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output csq_ctl_t      ctl_o
);
  localparam logic [1:0] SIZE_CODE = 2'($clog2(WORD_BYTES));

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    ctl_o   = CTL_IDLE;
    case (state_i)
      ST_DECODE: begin
        addr_o      = fetch_addr_i;
        ctl_o.size  = SIZE_CODE;
        ctl_o.req_n = cpa_i | cpb_i;
        ctl_o.opc_n = 1'b0;
        ctl_o.cpi_n = 1'b0;
      end
      ST_WAIT: begin
        addr_o      = fetch_addr_i;
        ctl_o.size  = SIZE_CODE;
        ctl_o.req_n = cpa_i | cpb_i;
        ctl_o.cpi_n = 1'b0;
      end
      ST_XFER: begin
        addr_o      = xfer_addr_i;
        wdata_o     = cp_wdata_i;
        ctl_o.size  = SIZE_CODE;
        ctl_o.write = 1'b1;
        ctl_o.req_n = 1'b0;
        ctl_o.seq   = !(cpa_i && cpb_i);
      end
      ST_HAND: begin
        addr_o      = resume_addr_i;
        ctl_o.size  = SIZE_CODE;
        ctl_o.opc_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/csq_store_seq.sv
module csq_store_seq
  import csq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  input  logic          cp_absent_i,
  input  logic          cp_busy_i,
  input  logic [DW-1:0] cp_wdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic          mem_write_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_req_n_o,
  output logic          mem_seq_o,
  output logic          opc_n_o,
  output logic          cpi_n_o,
  output logic          done_o,
  output logic          absent_o
);
  localparam int WORD_BYTES = DW / 8;

  logic          rst_int_n;
  csq_state_e    state;
  logic          load, step;
  logic [AW-1:0] fetch_addr, resume_addr, xfer_addr;
  csq_ctl_t      ctl;

  csq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  csq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i),
    .cpa_i(cp_absent_i), .cpb_i(cp_busy_i),
    .state_o(state), .load_o(load), .step_o(step), .absent_o(absent_o)
  );

  csq_addr #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .step_i(step),
    .pc_i(pc_i), .base_i(base_i),
    .fetch_addr_o(fetch_addr), .resume_addr_o(resume_addr),
    .xfer_addr_o(xfer_addr)
  );

  csq_drive #(.AW(AW), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_drive (
    .state_i(state), .cpa_i(cp_absent_i), .cpb_i(cp_busy_i),
    .cp_wdata_i(cp_wdata_i), .fetch_addr_i(fetch_addr),
    .resume_addr_i(resume_addr), .xfer_addr_i(xfer_addr),
    .addr_o(mem_addr_o), .wdata_o(mem_wdata_o), .ctl_o(ctl)
  );

  assign mem_size_o  = ctl.size;
  assign mem_write_o = ctl.write;
  assign mem_req_n_o = ctl.req_n;
  assign mem_seq_o   = ctl.seq;
  assign opc_n_o     = ctl.opc_n;
  assign cpi_n_o     = ctl.cpi_n;
  assign done_o      = (state == ST_HAND);
endmodule

// File: rtl/csq_store_seq_chk.sv
module csq_store_seq_chk #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cp_absent_i,
  input logic          cp_busy_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_size_o,
  input logic          mem_write_o,
  input logic          mem_req_n_o,
  input logic          mem_seq_o,
  input logic          opc_n_o,
  input logic          cpi_n_o,
  input logic          done_o,
  input logic          absent_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  // R2 / R3: while the strobe is low, the request follows the handshake
  assert_req_tracks_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpi_n_o && !cp_absent_i) |-> (mem_req_n_o == cp_busy_i));

  assert_xfer_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write_o |-> (!mem_req_n_o && opc_n_o && cpi_n_o && mem_size_o == 2'd2));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write_o && mem_seq_o) |=> (mem_write_o && mem_addr_o == $past(mem_addr_o) + STEP));

  assert_final_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write_o && !mem_seq_o) |=> done_o);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && mem_req_n_o && cpi_n_o && !mem_write_o));

  assert_absent_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    absent_o |=> !absent_o);

  assert_absent_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    absent_o |-> (!done_o && !mem_write_o && cpi_n_o));
endmodule

bind csq_store_seq csq_store_seq_chk #(.AW(AW), .WORD_BYTES(DW / 8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cp_absent_i(cp_absent_i), .cp_busy_i(cp_busy_i),
  .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_write_o(mem_write_o),
  .mem_req_n_o(mem_req_n_o), .mem_seq_o(mem_seq_o), .opc_n_o(opc_n_o),
  .cpi_n_o(cpi_n_o), .done_o(done_o), .absent_o(absent_o)
);

// File: tb/sim_csq_store_seq.sv
`timescale 1ns/1ps
module sim_csq_store_seq;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] pc, base;
  logic          cpa, cpb;
  logic [DW-1:0] cpd;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic          wr, reqn, seq, opcn, cpin, done, absent;
  logic [DW-1:0] wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  csq_store_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pc_i(pc), .base_i(base),
    .cp_absent_i(cpa), .cp_busy_i(cpb), .cp_wdata_i(cpd),
    .mem_addr_o(addr), .mem_size_o(size), .mem_write_o(wr), .mem_wdata_o(wdata),
    .mem_req_n_o(reqn), .mem_seq_o(seq), .opc_n_o(opcn), .cpi_n_o(cpin),
    .done_o(done), .absent_o(absent)
  );

  task automatic cyc(input logic a, input logic b, input logic [DW-1:0] d, input logic st);
    @(posedge clk);
    #2;
    cpa = a; cpb = b; cpd = d; start = st;
    #3;
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] e_addr, input logic [1:0] e_sz,
                     input logic e_wr, input logic e_rq, input logic e_sq, input logic e_op,
                     input logic e_ci, input logic e_dn, input logic e_ab);
    logic [40:0] act, exp;
    act = {addr, size, wr, reqn, seq, opcn, cpin, done, absent};
    exp = {e_addr, e_sz, e_wr, e_rq, e_sq, e_op, e_ci, e_dn, e_ab};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_data(input string tag, input logic [DW-1:0] e);
    n_chk++;
    if (wdata !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, wdata, e);
    end
  endtask

  task automatic chk_idle(input string tag, input logic e_ab);
    chk(tag, '0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, e_ab);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; pc = '0; base = '0; cpa = 1'b0; cpb = 1'b0; cpd = '0;
    repeat (3) @(posedge clk);
    #5;
    chk_idle("R1 idle in reset", 1'b0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk_idle("R1 idle after reset", 1'b0);
  endtask

  task automatic t_single_ready(input logic [AW-1:0] p, input logic [AW-1:0] bs, input logic [DW-1:0] d);
    pc = p; base = bs;
    cyc(0, 0, '0, 1); chk_idle("R1 idle on start cycle", 1'b0);
    cyc(0, 0, '0, 0); chk("R2 decode ready", p + 8, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, d, 0);  chk("R4 R5 single word", bs, 2'd2, 1, 0, 0, 1, 1, 0, 0);
    chk_data("R4 single word data", d);
    cyc(0, 0, '0, 0); chk("R6 hand-back", p + 12, 2'd2, 0, 1, 0, 0, 1, 1, 0);
    cyc(0, 0, '0, 0); chk_idle("R6 idle after done", 1'b0);
  endtask

  task automatic t_single_busy(input logic [AW-1:0] p, input logic [AW-1:0] bs, input int nb);
    pc = p; base = bs;
    cyc(0, 0, '0, 1);
    cyc(0, 1, '0, 0); chk("R2 decode busy", p + 8, 2'd2, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 1; i < nb; i++) begin
      cyc(0, 1, '0, 0); chk("R3 wait busy", p + 8, 2'd2, 0, 1, 0, 1, 0, 0, 0);
    end
    cyc(0, 0, '0, 0); chk("R3 last wait", p + 8, 2'd2, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, 1, 32'hC0FFEE01, 0); chk("R4 R5 word after wait", bs, 2'd2, 1, 0, 0, 1, 1, 0, 0);
    chk_data("R4 data after wait", 32'hC0FFEE01);
    cyc(0, 0, '0, 0); chk("R6 hand-back after wait", p + 12, 2'd2, 0, 1, 0, 0, 1, 1, 0);
    cyc(0, 0, '0, 0); chk_idle("R6 idle after wait run", 1'b0);
  endtask

  task automatic t_multi(input logic [AW-1:0] p, input logic [AW-1:0] bs, input int n, input logic poke);
    pc = p; base = bs;
    cyc(0, 0, '0, 1);
    cyc(0, 0, '0, 0); chk("R2 decode multi", p + 8, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n - 1; i++) begin
      logic st;
      st = poke && (i == 1);
      if (st) begin pc = p ^ 32'h0000_F000; base = bs ^ 32'h0000_0F00; end
      cyc(0, 0, 32'hA500_0000 + DW'(i), st);
      chk("R4 R5 R9 middle word", bs + AW'(4 * i), 2'd2, 1, 0, 1, 1, 1, 0, 0);
      chk_data("R4 middle data", 32'hA500_0000 + DW'(i));
    end
    cyc(1, 1, 32'h5A5A_0000, 0);
    chk("R5 R9 final word", bs + AW'(4 * (n - 1)), 2'd2, 1, 0, 0, 1, 1, 0, 0);
    chk_data("R4 final data", 32'h5A5A_0000);
    cyc(0, 0, '0, 0); chk("R6 R8 hand-back multi", p + 12, 2'd2, 0, 1, 0, 0, 1, 1, 0);
    cyc(0, 0, '0, 0); chk_idle("R8 idle, stray start ignored", 1'b0);
    cyc(0, 0, '0, 0); chk_idle("R8 still idle", 1'b0);
  endtask

  task automatic t_absent(input logic [AW-1:0] p, input logic in_wait);
    pc = p; base = 32'h0000_8000;
    cyc(0, 0, '0, 1);
    if (in_wait) begin
      cyc(0, 1, '0, 0); chk("R2 decode before absent", p + 8, 2'd2, 0, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, '0, 0); chk("R3 R7 wait with absent", p + 8, 2'd2, 0, 1, 0, 1, 0, 0, 0);
    end else begin
      cyc(1, 0, '0, 0); chk("R2 R7 decode absent", p + 8, 2'd2, 0, 1, 0, 0, 0, 0, 0);
    end
    cyc(0, 0, '0, 0); chk_idle("R7 absent pulse", 1'b1);
    cyc(0, 0, '0, 0); chk_idle("R7 absent cleared, no transfer", 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_ready(32'h0000_1000, 32'h0002_0040, 32'hDEAD_BEEF);
    t_single_busy(32'h0000_2000, 32'h0003_0100, 3);
    t_multi(32'h0000_3000, 32'h0004_0000, 4, 1'b0);
    t_multi(32'hFFFF_FFF8, 32'hFFFF_FFF8, 4, 1'b1);
    t_absent(32'h0000_4000, 1'b0);
    t_absent(32'h0000_5000, 1'b1);
    t_single_ready(32'h0000_6000, 32'h0001_0000, 32'h1234_5678);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule